// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the slave end of a three-wire serial EEPROM. The array lives on chip. A host drives a chip select, a serial clock and a serial data input. The block answers on a serial data output and also drives an output-enable, which stands for the high-impedance state of the pin. A static organisation input sets the data unit. When it is high, the array is 256 locations of 16 bits. When it is low, the same storage is 512 locations of 8 bits.

Each instruction opens with a start bit. Two opcode bits and an address follow. The block handles read, write, erase, and a pair of extended commands. These commands arm and disarm a write-enable latch that guards every change to the array.

A read emits a leading zero, then the addressed data. The data keeps flowing from the next locations for as long as select stays high. A write or erase is committed when select falls. It then starts a programming interval of fixed length. The host can see that interval as a ready/busy level on the output by raising select again.

The serial pins are synchronised to the fast system clock, and every action is keyed to a detected rising edge of the serial clock.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear. WRITE and ERASE then change no location until an enable command has been decoded.
- R2: Opcode 00 is the extended group. If the two most significant address bits are 11, the latch is set. If they are 00, the latch is cleared. The latch keeps its value between these commands.
- R3: READ returns the stored data whether the latch is set or clear.
- R4: On READ, dout goes to 0 on the serial-clock rising edge that carries the last address bit. On each following rising edge, dout presents one data bit, most significant bit first.
- R5: With org=1 there are 8 address bits and the data unit is 16 bits. With org=0 there are 9 address bits and the data unit is 8 bits. In that mode, address bit 0 set to 1 selects the upper half of the 16-bit word indexed by the remaining 8 bits.
- R6: dout_oe is 0 after reset and whenever select is low.
- R7: While select stays high after a complete data unit, the address increments and the next unit follows at once with no extra zero. The address wraps from the top location to 0.
- R8: An instruction begins at the first serial-clock rising edge that sees di=1 while select is high. Leading zeros are ignored. The two opcode bits, first bit most significant, decode as 10=READ, 01=WRITE, 11=ERASE, 00=extended.
- R9: WRITE stores its data on the fall of select only if a full data unit was shifted in and the latch is set. A shorter WRITE changes nothing and starts no programming interval.
- R10: ERASE sets the addressed unit to all ones.
- R11: After a commit, raising select gives dout_oe=1 with dout=0 for BUSY_CYC clocks, and dout=1 after that. Any instruction that arrives during the interval is ignored until select falls.
- R12: A serial-clock rising edge that is seen in the same clock as the fall of select is not taken as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| org | input | 1 | Organisation: 1 = 16-bit units, 0 = 8-bit units |
| dout | output | 1 | Serial data or ready/busy level |
| dout_oe | output | 1 | Output enable; 0 means the pin floats |

## Verification
Two events can land in one clock after synchronisation: the fall of select and a serial-clock rising edge. The bench provokes this by shifting a write one bit short of a full word. It then raises the serial clock in the same instant that it lowers select, with di=1. The coincident edge must not complete the word. The bench judges the result at the pins: the location must read back unchanged, and raising select again must show no ready/busy level.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } mw_state_e;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/mw_busy.sv
module mw_busy #(
  parameter int CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  parameter int IDX_W  = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [IDX_W-1:0]        widx,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [IDX_W-1:0]        ridx,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[widx] <= wdata[g*LANE_W +: LANE_W];
      rdata[g*LANE_W +: LANE_W] <= mem[ridx];
    end
  end
endmodule

// File: rtl/mw_decoder.sv
module mw_decoder
  import mw_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              org,
  input  logic              cs_s,
  input  logic              sk_s,
  input  logic              di_s,
  input  logic              busy,
  input  logic [WORD_W-1:0] rdata,
  output logic [IDX_W-1:0]  ridx,
  output logic [1:0]        we,
  output logic [IDX_W-1:0]  widx,
  output logic [WORD_W-1:0] wdata,
  output logic              wen,
  output logic              rd_on,
  output logic              rd_bit,
  output logic              status,
  output logic              idle
);
  localparam int ADDR_W = IDX_W + 1;
  localparam int HALF_W = WORD_W / 2;
  localparam int MAXB   = (WORD_W > ADDR_W) ? WORD_W : ADDR_W;
  localparam int CNT_W  = $clog2(MAXB + 1);

  mw_state_e         state;
  logic [1:0]        op;
  logic [CNT_W-1:0]  cnt, rem, abits, dbits;
  logic [ADDR_W-1:0] addr, nxt_addr, addr_inc;
  logic [WORD_W-1:0] dat, sh, rword;
  logic [1:0]        ext_top;
  logic              need_load, pend, lock, sk_d, cs_d;
  logic              sk_rise, cs_fall, rise_ok;

  always_comb begin
    sk_rise  = sk_s & ~sk_d;
    cs_fall  = cs_d & ~cs_s;
    rise_ok  = sk_rise & cs_s;
    abits    = org ? CNT_W'(IDX_W) : CNT_W'(ADDR_W);
    dbits    = org ? CNT_W'(WORD_W) : CNT_W'(HALF_W);
    nxt_addr = {addr[ADDR_W-2:0], di_s};
    ext_top  = org ? nxt_addr[IDX_W-1 -: 2] : nxt_addr[ADDR_W-1 -: 2];
    ridx     = org ? addr[IDX_W-1:0] : addr[ADDR_W-1:1];
    addr_inc = org ? {1'b0, addr[IDX_W-1:0] + 1'b1} : addr + 1'b1;
    if (org) rword = rdata;
    else     rword = {(addr[0] ? rdata[WORD_W-1:HALF_W] : rdata[HALF_W-1:0]),
                      {HALF_W{1'b0}}};
    idle     = (state == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; op <= 2'b00; cnt <= '0; rem <= '0;
      addr <= '0; dat <= '0; sh <= '0;
      need_load <= 1'b0; pend <= 1'b0; lock <= 1'b0;
      sk_d <= 1'b0; cs_d <= 1'b0;
      wen <= 1'b0; rd_on <= 1'b0; rd_bit <= 1'b0; status <= 1'b0;
      we <= 2'b00; widx <= '0; wdata <= '0;
    end else begin
      sk_d <= sk_s;
      cs_d <= cs_s;
      we   <= 2'b00;
      if (cs_fall) begin
        state     <= ST_IDLE;
        rd_on     <= 1'b0;
        need_load <= 1'b0;
        lock      <= 1'b0;
        pend      <= 1'b0;
        if (pend && wen) begin
          we     <= org ? 2'b11 : (addr[0] ? 2'b10 : 2'b01);
          widx   <= ridx;
          wdata  <= (op == OP_ERASE) ? '1 :
                    (org ? dat : {2{dat[HALF_W-1:0]}});
          status <= 1'b1;
        end
      end else if (rise_ok) begin
        unique case (state)
          ST_IDLE: begin
            if (busy) lock <= 1'b1;
            else if (di_s && !lock) begin
              state  <= ST_OPC;
              cnt    <= '0;
              addr   <= '0;
              dat    <= '0;
              status <= 1'b0;
            end
          end
          ST_OPC: begin
            op  <= {op[0], di_s};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(1)) begin
              state <= ST_ADDR;
              cnt   <= '0;
            end
          end
          ST_ADDR: begin
            addr <= nxt_addr;
            cnt  <= cnt + 1'b1;
            if (cnt == abits - CNT_W'(1)) begin
              cnt <= '0;
              unique case (op)
                OP_READ: begin
                  state <= ST_READ; rd_on <= 1'b1;
                  rd_bit <= 1'b0; need_load <= 1'b1;
                end
                OP_WRITE: state <= ST_DATA;
                OP_ERASE: begin state <= ST_HOLD; pend <= 1'b1; end
                default: begin
                  state <= ST_HOLD;
                  if (ext_top == 2'b11)      wen <= 1'b1;
                  else if (ext_top == 2'b00) wen <= 1'b0;
                end
              endcase
            end
          end
          ST_DATA: begin
            dat <= {dat[WORD_W-2:0], di_s};
            cnt <= cnt + 1'b1;
            if (cnt == dbits - CNT_W'(1)) begin
              state <= ST_HOLD;
              pend  <= 1'b1;
            end
          end
          ST_READ: begin
            if (need_load) begin
              sh        <= rword << 1;
              rd_bit    <= rword[WORD_W-1];
              rem       <= dbits - CNT_W'(1);
              need_load <= 1'b0;
            end else begin
              rd_bit <= sh[WORD_W-1];
              sh     <= sh << 1;
              rem    <= rem - 1'b1;
              if (rem == CNT_W'(1)) begin
                need_load <= 1'b1;
                addr      <= addr_inc;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int IDX_W       = 8,
  parameter int WORD_W      = 16,
  parameter int BUSY_CYC    = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic dout,
  output logic dout_oe
);
  localparam int HALF_W = WORD_W / 2;

  logic [2:0]        pins_s;
  logic              cs_s, sk_s, di_s;
  logic              busy, wen, rd_on, rd_bit, status, dec_idle;
  logic [1:0]        mem_we;
  logic [IDX_W-1:0]  ridx, widx;
  logic [WORD_W-1:0] rdata, wdata;

  mw_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({cs, sk, di}), .dout(pins_s)
  );
  assign cs_s = pins_s[2];
  assign sk_s = pins_s[1];
  assign di_s = pins_s[0];

  mw_decoder #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_dec (
    .clk(clk), .rst(rst), .org(org), .cs_s(cs_s), .sk_s(sk_s), .di_s(di_s),
    .busy(busy), .rdata(rdata), .ridx(ridx), .we(mem_we), .widx(widx),
    .wdata(wdata), .wen(wen), .rd_on(rd_on), .rd_bit(rd_bit),
    .status(status), .idle(dec_idle)
  );

  mw_store #(.LANE_W(HALF_W), .LANES(2), .IDX_W(IDX_W)) u_store (
    .clk(clk), .we(mem_we), .widx(widx), .wdata(wdata),
    .ridx(ridx), .rdata(rdata)
  );

  mw_busy #(.CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst(rst), .start(|mem_we), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      dout    <= rd_on ? rd_bit : ~busy;
      dout_oe <= cs_s & (rd_on | status);
    end
  end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_s,
  input logic       dout_oe,
  input logic       wen,
  input logic       busy,
  input logic       rd_on,
  input logic       rd_bit,
  input logic       idle,
  input logic [1:0] we
);
  AST_LATCH_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wen);  // R1
  AST_NO_PROG_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (|we) |-> wen);  // R9
  AST_PROG_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (|we) |=> busy);  // R11
  AST_BUSY_HOLDS_DECODER: assert property (@(posedge clk) disable iff (rst)
    busy |-> idle);  // R11
  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(cs_s));  // R6
  AST_DUMMY_ZERO_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_on) |-> !rd_bit);  // R4
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .dout_oe(dout_oe), .wen(wen),
  .busy(busy), .rd_on(rd_on), .rd_bit(rd_bit), .idle(dec_idle), .we(mem_we)
);

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;
  localparam int HALF = 8;
  localparam int BUSY = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic dout, dout_oe;
  int   n_chk = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;

  mw_eeprom #(.BUSY_CYC(BUSY)) u_mw_eeprom (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .org(org),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic d, output logic q);
    di = d;
    repeat (HALF) @(posedge clk);
    #1 sk = 1'b1;
    repeat (HALF) @(posedge clk);
    #1 q = dout;
    sk = 1'b0;
  endtask

  task automatic cs_up();
    @(posedge clk); #1 cs = 1'b1;
  endtask

  task automatic cs_down();
    repeat (HALF) @(posedge clk);
    #1 cs = 1'b0; sk = 1'b0; di = 1'b0;
    repeat (2*HALF) @(posedge clk);
    #1;
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [8:0] a, output logic last);
    logic q;
    pulse(1'b1, q); pulse(op[1], q); pulse(op[0], q);
    for (int i = (org ? 7 : 8); i >= 0; i--) pulse(a[i], q);
    last = q;
  endtask

  task automatic ext_cmd(input logic enable);
    logic q;
    cs_up();
    send_hdr(2'b00, enable ? (org ? 9'h0C0 : 9'h180) : 9'h000, q);
    cs_down();
  endtask

  task automatic write_loc(input logic [8:0] a, input logic [15:0] d);
    logic q;
    cs_up();
    send_hdr(2'b01, a, q);
    for (int i = (org ? 15 : 7); i >= 0; i--) pulse(d[i], q);
    cs_down();
    repeat (BUSY + 20) @(posedge clk);
  endtask

  task automatic erase_loc(input logic [8:0] a);
    logic q;
    cs_up();
    send_hdr(2'b11, a, q);
    cs_down();
    repeat (BUSY + 20) @(posedge clk);
  endtask

  task automatic read_seq(input logic [8:0] a, input int n, output logic dm,
                          output logic [15:0] w0, output logic [15:0] w1);
    logic q;
    w0 = '0; w1 = '0;
    cs_up();
    send_hdr(2'b10, a, dm);
    for (int i = 0; i < (org ? 16 : 8); i++) begin pulse(1'b0, q); w0 = {w0[14:0], q}; end
    if (n > 1)
      for (int i = 0; i < (org ? 16 : 8); i++) begin pulse(1'b0, q); w1 = {w1[14:0], q}; end
    cs_down();
  endtask

  task automatic t_reset();
    chk("R6 oe after reset", {15'd0, dout_oe}, 16'd0);
  endtask

  task automatic t_enable_gate();
    logic dm; logic [15:0] w0, w1;
    org = 1'b1;
    ext_cmd(1'b1);
    write_loc(9'd10, 16'h1234);
    read_seq(9'd10, 1, dm, w0, w1);
    chk("R2 write with latch set", w0, 16'h1234);
    ext_cmd(1'b0);
    write_loc(9'd10, 16'hFFFF);
    erase_loc(9'd10);
    read_seq(9'd10, 1, dm, w0, w1);
    chk("R2 write/erase after disable", w0, 16'h1234);
    chk("R3 read with latch clear", w0, 16'h1234);
  endtask

  task automatic t_reset_lock();
    logic dm; logic [15:0] w0, w1;
    ext_cmd(1'b1);
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk); #1 rst = 1'b0;
    write_loc(9'd10, 16'h0000);
    read_seq(9'd10, 1, dm, w0, w1);
    chk("R1 write ignored after reset", w0, 16'h1234);
  endtask

  task automatic t_read_basic();
    logic dm; logic [15:0] w0, w1;
    ext_cmd(1'b1);
    write_loc(9'd40, 16'h8001);
    read_seq(9'd40, 1, dm, w0, w1);
    chk("R4 dummy zero", {15'd0, dm}, 16'd0);
    chk("R4 msb first data", w0, 16'h8001);
    chk("R6 oe after select low", {15'd0, dout_oe}, 16'd0);
  endtask

  task automatic t_leading_zero();
    logic q, dm; logic [15:0] w0;
    cs_up();
    pulse(1'b0, q); pulse(1'b0, q); pulse(1'b0, q);
    send_hdr(2'b10, 9'd40, dm);
    w0 = '0;
    for (int i = 0; i < 16; i++) begin pulse(1'b0, q); w0 = {w0[14:0], q}; end
    cs_down();
    chk("R8 leading zeros ignored", w0, 16'h8001);
  endtask

  task automatic t_partial();
    logic q, dm; logic [15:0] w0, w1;
    cs_up();
    send_hdr(2'b01, 9'd10, q);
    for (int i = 0; i < 7; i++) pulse(1'b0, q);
    cs_down();
    cs_up();
    repeat (HALF) @(posedge clk); #1;
    chk("R9 no busy after short write", {15'd0, dout_oe}, 16'd0);
    cs_down();
    read_seq(9'd10, 1, dm, w0, w1);
    chk("R9 short write no change", w0, 16'h1234);
  endtask

  task automatic t_busy();
    logic q, dm; logic [15:0] w0, w1;
    cs_up();
    send_hdr(2'b01, 9'd20, q);
    for (int i = 15; i >= 0; i--) pulse(w0_const(i), q);
    cs_down();
    cs_up();
    repeat (HALF) @(posedge clk); #1;
    chk("R11 busy level", {14'd0, dout_oe, dout}, 16'h0002);
    send_hdr(2'b01, 9'd20, q);
    for (int i = 0; i < 16; i++) pulse(1'b0, q);
    repeat (BUSY) @(posedge clk); #1;
    chk("R11 ready level", {14'd0, dout_oe, dout}, 16'h0003);
    cs_down();
    read_seq(9'd20, 1, dm, w0, w1);
    chk("R11 write during busy ignored", w0, 16'hABCD);
  endtask

  function automatic logic w0_const(input int i);
    logic [15:0] v = 16'hABCD;
    return v[i];
  endfunction

  task automatic t_erase();
    logic dm; logic [15:0] w0, w1;
    erase_loc(9'd20);
    read_seq(9'd20, 1, dm, w0, w1);
    chk("R10 erase gives ones", w0, 16'hFFFF);
  endtask

  task automatic t_wrap();
    logic dm; logic [15:0] w0, w1;
    write_loc(9'd255, 16'hA5C3);
    write_loc(9'd0, 16'h0F1E);
    read_seq(9'd255, 2, dm, w0, w1);
    chk("R7 first word", w0, 16'hA5C3);
    chk("R7 wrapped word", w1, 16'h0F1E);
  endtask

  task automatic t_bytes();
    logic dm; logic [15:0] w0, w1;
    org = 1'b0;
    ext_cmd(1'b1);
    write_loc(9'd4, 16'h0011);
    write_loc(9'd5, 16'h00C3);
    write_loc(9'd6, 16'h005A);
    read_seq(9'd5, 2, dm, w0, w1);
    chk("R5 byte read", w0, 16'h00C3);
    chk("R5 next byte", w1, 16'h005A);
    org = 1'b1;
    repeat (4) @(posedge clk);
    read_seq(9'd2, 1, dm, w0, w1);
    chk("R5 byte lanes in word", w0, 16'hC311);
  endtask

  task automatic t_coincide();
    logic q, dm; logic [15:0] w0, w1;
    write_loc(9'd30, 16'h1111);
    cs_up();
    send_hdr(2'b01, 9'd30, q);
    for (int i = 0; i < 15; i++) pulse(1'b0, q);
    di = 1'b1;
    repeat (HALF) @(posedge clk);
    #1 sk = 1'b1; cs = 1'b0;
    repeat (2*HALF) @(posedge clk);
    #1 sk = 1'b0; di = 1'b0;
    repeat (BUSY + 20) @(posedge clk);
    cs_up();
    repeat (HALF) @(posedge clk); #1;
    chk("R12 no commit from coincident edge", {15'd0, dout_oe}, 16'd0);
    cs_down();
    read_seq(9'd30, 1, dm, w0, w1);
    chk("R12 location unchanged", w0, 16'h1111);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge clk); #1;
    t_reset();
    t_enable_gate();
    t_reset_lock();
    t_read_basic();
    t_leading_zero();
    t_partial();
    t_busy();
    t_erase();
    t_wrap();
    t_bytes();
    t_coincide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule